// File: doc/BRIEF.md
# Store Buffer with Load Disambiguation

This block holds stores from an out-of-order core in program order until they can safely write a single-ported data cache. The core allocates an entry for each store as it is dispatched. It later supplies the store's address and its data, each identified by the store's age tag. The reorder buffer then commits the store by the same tag. The oldest entry is offered to the cache only once its address and data are known and it has been committed. Entries leave one at a time, oldest first, whenever the cache accepts a write.

Every load the core presents is checked against the stores in the buffer that are older than it. If any older store still lacks its address, the load is told to stall and retry. If the youngest older store that hits the same 32-bit word has its data, that data is forwarded and the cache read is skipped. If that store has no data yet, the load stalls. With no older match, the load may read the cache. A flush drops every uncommitted entry and keeps committed ones so they still drain.

Top module: `store_buffer`

## Requirements
- R1: While reset is high and in the first cycle after it, alloc_ready is 1, cache_wr_valid is 0 and ld_resp_valid is 0.
- R2: An allocation is taken when alloc_valid and alloc_ready are both high. alloc_ready falls once DEPTH entries are held, and an allocation offered while it is low is dropped.
- R3: A store is not offered on the cache port until its address is known, its data is known and it has been committed, in any order of these three events.
- R4: Stores leave for the cache strictly oldest first, one per cycle in which cache_wr_ready is high. While cache_wr_ready is low, the offered address and data stay unchanged.
- R5: Each load request produces a response on the next cycle that echoes its tag. ld_resp_kind is 0 for stall (retry), 1 for go to cache and 2 for forwarded, and it never takes the value 3.
- R6: A buffered store counts as older than a load when (ld_tag - store tag) mod 2^TAGW lies in 1 .. 2^(TAGW-1)-1. Stores that are equal in age or younger have no effect on the load.
- R7: A load stalls if any older buffered store has an unknown address.
- R8: Matching compares address bits [AW-1:2]. The youngest older matching store forwards its data if that data is known, and the load stalls if it is not.
- R9: A load with no older matching store, and no older store of unknown address, gets kind 1. ld_resp_data is 0 for every kind other than forwarded.
- R10: In a flush cycle, uncommitted entries are removed and committed entries stay and drain later. Allocation, address, data and commit inputs are ignored in that cycle.
- R11: Address, data and commit updates apply only to an allocated entry whose tag equals the given tag. An update with no matching tag changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a store entry |
| alloc_tag | input | TAGW | Age tag of the new store |
| alloc_ready | output | 1 | Room for an allocation |
| addr_we | input | 1 | Store address update |
| addr_tag | input | TAGW | Tag of the store receiving the address |
| addr_in | input | AW | Store address |
| data_we | input | 1 | Store data update |
| data_tag | input | TAGW | Tag of the store receiving the data |
| data_in | input | DW | Store data |
| commit_valid | input | 1 | Commit pulse |
| commit_tag | input | TAGW | Tag of the committed store |
| flush | input | 1 | Drop uncommitted entries |
| ld_valid | input | 1 | Load request |
| ld_tag | input | TAGW | Age tag of the load |
| ld_addr | input | AW | Load address |
| ld_resp_valid | output | 1 | Load response present |
| ld_resp_tag | output | TAGW | Tag of the answered load |
| ld_resp_kind | output | 2 | 0 stall, 1 cache, 2 forwarded |
| ld_resp_data | output | DW | Forwarded data, else 0 |
| cache_wr_valid | output | 1 | Oldest store offered to the cache |
| cache_wr_addr | output | AW | Offered store address |
| cache_wr_data | output | DW | Offered store data |
| cache_wr_ready | input | 1 | Cache accepts the offered write |

## Verification
A load's verdict is registered, so it appears on the clock edge after the edge that samples ld_valid. It reflects the buffer state before any update made at that same edge. The bench drives each request on a falling edge and reads the response on the next falling edge. An address, data or commit update shows on the cache port one edge after it is sampled. The bench therefore checks cache_wr_valid one falling edge after each update. A drained write is recorded at the falling edge where both valid and ready are high, since the pop takes place at the rising edge that follows.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    LD_STALL = 2'd0,
    LD_CACHE = 2'd1,
    LD_FWD   = 2'd2
  } ld_kind_e;
endpackage

// File: rtl/sb_tag_match.sv
module sb_tag_match #(
  parameter int DEPTH = 8,
  parameter int TAGW  = 6
) (
  input  logic                       en,
  input  logic [TAGW-1:0]            key,
  input  logic [DEPTH-1:0]           vld,
  input  logic [DEPTH-1:0][TAGW-1:0] tags,
  output logic [DEPTH-1:0]           hit
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = en && vld[g] && (tags[g] == key);
  end
endmodule

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TAGW  = 6,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_valid,
  input  logic [TAGW-1:0]            alloc_tag,
  output logic                       alloc_ready,
  input  logic                       addr_we,
  input  logic [TAGW-1:0]            addr_tag,
  input  logic [AW-1:0]              addr_in,
  input  logic                       data_we,
  input  logic [TAGW-1:0]            data_tag,
  input  logic [DW-1:0]              data_in,
  input  logic                       commit_valid,
  input  logic [TAGW-1:0]            commit_tag,
  input  logic                       flush,
  input  logic                       cache_wr_ready,
  output logic                       cache_wr_valid,
  output logic [AW-1:0]              cache_wr_addr,
  output logic [DW-1:0]              cache_wr_data,
  output logic [IDXW-1:0]            head_o,
  output logic [DEPTH-1:0]           vld_o,
  output logic [DEPTH-1:0]           aok_o,
  output logic [DEPTH-1:0]           dok_o,
  output logic [DEPTH-1:0][TAGW-1:0] tag_o,
  output logic [DEPTH-1:0][AW-3:0]   word_o,
  output logic [DEPTH-1:0][DW-1:0]   data_o
);
  localparam int CNTW = IDXW + 1;

  logic [IDXW-1:0]            head, tail;
  logic [CNTW-1:0]            count, ncmt;
  logic [DEPTH-1:0]           vld, aok, dok, cmt;
  logic [DEPTH-1:0][TAGW-1:0] tag_q;
  logic [DEPTH-1:0][AW-1:0]   addr_q;
  logic [DEPTH-1:0][DW-1:0]   data_q;
  logic [DEPTH-1:0]           a_hit, d_hit, c_hit;
  logic                       push, pop;

  sb_tag_match #(.DEPTH(DEPTH), .TAGW(TAGW)) u_amatch (
    .en(addr_we && !flush), .key(addr_tag), .vld(vld), .tags(tag_q), .hit(a_hit));
  sb_tag_match #(.DEPTH(DEPTH), .TAGW(TAGW)) u_dmatch (
    .en(data_we && !flush), .key(data_tag), .vld(vld), .tags(tag_q), .hit(d_hit));
  sb_tag_match #(.DEPTH(DEPTH), .TAGW(TAGW)) u_cmatch (
    .en(commit_valid && !flush), .key(commit_tag), .vld(vld), .tags(tag_q), .hit(c_hit));

  assign alloc_ready    = (count != CNTW'(DEPTH));
  assign cache_wr_valid = vld[head] && aok[head] && dok[head] && cmt[head];
  assign cache_wr_addr  = addr_q[head];
  assign cache_wr_data  = data_q[head];
  assign push = alloc_valid && alloc_ready && !flush;
  assign pop  = cache_wr_valid && cache_wr_ready;

  always_comb begin
    ncmt = '0;
    for (int i = 0; i < DEPTH; i++) ncmt = ncmt + CNTW'(vld[i] & cmt[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      vld   <= '0;
      aok   <= '0;
      dok   <= '0;
      cmt   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (a_hit[i]) aok[i] <= 1'b1;
        if (d_hit[i]) dok[i] <= 1'b1;
        if (c_hit[i]) cmt[i] <= 1'b1;
        if (flush && !cmt[i]) vld[i] <= 1'b0;
      end
      if (pop) begin
        vld[head] <= 1'b0;
        cmt[head] <= 1'b0;
        head      <= head + 1'b1;
      end
      if (push) begin
        vld[tail] <= 1'b1;
        aok[tail] <= 1'b0;
        dok[tail] <= 1'b0;
        cmt[tail] <= 1'b0;
        tail      <= tail + 1'b1;
      end
      if (flush) begin
        tail  <= head + IDXW'(ncmt);
        count <= ncmt - CNTW'(pop);
      end else begin
        count <= count + CNTW'(push) - CNTW'(pop);
      end
    end
  end

  // payload storage carries no reset
  always_ff @(posedge clk) begin
    if (push) tag_q[tail] <= alloc_tag;
    for (int i = 0; i < DEPTH; i++) begin
      if (a_hit[i]) addr_q[i] <= addr_in;
      if (d_hit[i]) data_q[i] <= data_in;
    end
  end

  assign head_o = head;
  assign vld_o  = vld;
  assign aok_o  = aok;
  assign dok_o  = dok;
  assign tag_o  = tag_q;
  assign data_o = data_q;
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign word_o[g] = addr_q[g][AW-1:2];
  end
endmodule

// File: rtl/sb_disambig.sv
module sb_disambig
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TAGW  = 6,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic [TAGW-1:0]            ld_tag,
  input  logic [AW-3:0]              ld_word,
  input  logic [IDXW-1:0]            head,
  input  logic [DEPTH-1:0]           vld,
  input  logic [DEPTH-1:0]           aok,
  input  logic [DEPTH-1:0]           dok,
  input  logic [DEPTH-1:0][TAGW-1:0] tag_q,
  input  logic [DEPTH-1:0][AW-3:0]   word_q,
  input  logic [DEPTH-1:0][DW-1:0]   data_q,
  output ld_kind_e                   kind,
  output logic [DW-1:0]              fwd_data
);
  logic            unknown, hit, hit_ok;
  logic [DW-1:0]   hit_data;
  logic [IDXW-1:0] idx;
  logic [TAGW-1:0] diff;

  // walk oldest to youngest so the last match is the youngest older store
  always_comb begin
    unknown  = 1'b0;
    hit      = 1'b0;
    hit_ok   = 1'b0;
    hit_data = '0;
    idx      = '0;
    diff     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx  = head + IDXW'(i);
      diff = ld_tag - tag_q[idx];
      if (vld[idx] && (diff != '0) && !diff[TAGW-1]) begin
        if (!aok[idx]) begin
          unknown = 1'b1;
        end else if (word_q[idx] == ld_word) begin
          hit      = 1'b1;
          hit_ok   = dok[idx];
          hit_data = data_q[idx];
        end
      end
    end
  end

  always_comb begin
    if (unknown || (hit && !hit_ok)) kind = LD_STALL;
    else if (hit)                    kind = LD_FWD;
    else                             kind = LD_CACHE;
    fwd_data = (kind == LD_FWD) ? hit_data : '0;
  end
endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int TAGW  = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_valid,
  input  logic [TAGW-1:0] alloc_tag,
  output logic            alloc_ready,
  input  logic            addr_we,
  input  logic [TAGW-1:0] addr_tag,
  input  logic [AW-1:0]   addr_in,
  input  logic            data_we,
  input  logic [TAGW-1:0] data_tag,
  input  logic [DW-1:0]   data_in,
  input  logic            commit_valid,
  input  logic [TAGW-1:0] commit_tag,
  input  logic            flush,
  input  logic            ld_valid,
  input  logic [TAGW-1:0] ld_tag,
  input  logic [AW-1:0]   ld_addr,
  output logic            ld_resp_valid,
  output logic [TAGW-1:0] ld_resp_tag,
  output logic [1:0]      ld_resp_kind,
  output logic [DW-1:0]   ld_resp_data,
  output logic            cache_wr_valid,
  output logic [AW-1:0]   cache_wr_addr,
  output logic [DW-1:0]   cache_wr_data,
  input  logic            cache_wr_ready
);
  localparam int IDXW = $clog2(DEPTH);

  logic [IDXW-1:0]            head;
  logic [DEPTH-1:0]           vld, aok, dok;
  logic [DEPTH-1:0][TAGW-1:0] tag_q;
  logic [DEPTH-1:0][AW-3:0]   word_q;
  logic [DEPTH-1:0][DW-1:0]   data_q;
  ld_kind_e                   kind;
  logic [DW-1:0]              fwd_data;
  logic                       unused_ld_lo;

  assign unused_ld_lo = ^ld_addr[1:0];

  sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW)) u_queue (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_ready(alloc_ready),
    .addr_we(addr_we), .addr_tag(addr_tag), .addr_in(addr_in),
    .data_we(data_we), .data_tag(data_tag), .data_in(data_in),
    .commit_valid(commit_valid), .commit_tag(commit_tag), .flush(flush),
    .cache_wr_ready(cache_wr_ready), .cache_wr_valid(cache_wr_valid),
    .cache_wr_addr(cache_wr_addr), .cache_wr_data(cache_wr_data),
    .head_o(head), .vld_o(vld), .aok_o(aok), .dok_o(dok),
    .tag_o(tag_q), .word_o(word_q), .data_o(data_q));

  sb_disambig #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW)) u_disambig (
    .ld_tag(ld_tag), .ld_word(ld_addr[AW-1:2]), .head(head),
    .vld(vld), .aok(aok), .dok(dok), .tag_q(tag_q), .word_q(word_q),
    .data_q(data_q), .kind(kind), .fwd_data(fwd_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_resp_valid <= 1'b0;
      ld_resp_tag   <= '0;
      ld_resp_kind  <= LD_STALL;
      ld_resp_data  <= '0;
    end else begin
      ld_resp_valid <= ld_valid;
      ld_resp_tag   <= ld_tag;
      ld_resp_kind  <= ld_valid ? kind : LD_STALL;
      ld_resp_data  <= ld_valid ? fwd_data : '0;
    end
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int TAGW = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            alloc_ready,
  input logic            ld_valid,
  input logic [TAGW-1:0] ld_tag,
  input logic            ld_resp_valid,
  input logic [TAGW-1:0] ld_resp_tag,
  input logic [1:0]      ld_resp_kind,
  input logic [DW-1:0]   ld_resp_data,
  input logic            cache_wr_valid,
  input logic [AW-1:0]   cache_wr_addr,
  input logic [DW-1:0]   cache_wr_data,
  input logic            cache_wr_ready
);
  // R1
  reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (alloc_ready && !cache_wr_valid && !ld_resp_valid));
  // R5
  resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> (ld_resp_valid && ld_resp_tag == $past(ld_tag)));
  // R5
  resp_kind_legal_chk: assert property (@(posedge clk) disable iff (rst)
    ld_resp_valid |-> (ld_resp_kind != 2'd3));
  // R4
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cache_wr_valid && !cache_wr_ready) |=>
      (cache_wr_valid && $stable(cache_wr_addr) && $stable(cache_wr_data)));
  // R9
  resp_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_resp_valid && ld_resp_kind != 2'd2) |-> (ld_resp_data == '0));
endmodule

bind store_buffer sb_checker #(.AW(AW), .DW(DW), .TAGW(TAGW)) u_sb_checker (
  .clk(clk), .rst(rst), .alloc_ready(alloc_ready),
  .ld_valid(ld_valid), .ld_tag(ld_tag),
  .ld_resp_valid(ld_resp_valid), .ld_resp_tag(ld_resp_tag),
  .ld_resp_kind(ld_resp_kind), .ld_resp_data(ld_resp_data),
  .cache_wr_valid(cache_wr_valid), .cache_wr_addr(cache_wr_addr),
  .cache_wr_data(cache_wr_data), .cache_wr_ready(cache_wr_ready));

// File: tb/store_buffer_bench.sv
`timescale 1ns/1ps
module store_buffer_bench;
  localparam int AW = 32, DW = 32, TAGW = 6, DEPTH = 8;
  localparam logic [1:0] K_STALL = 2'd0, K_CACHE = 2'd1, K_FWD = 2'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 0, addr_we = 0, data_we = 0, commit_valid = 0, flush = 0;
  logic ld_valid = 0, cache_wr_ready = 0;
  logic [TAGW-1:0] alloc_tag = '0, addr_tag = '0, data_tag = '0, commit_tag = '0, ld_tag = '0;
  logic [AW-1:0] addr_in = '0, ld_addr = '0;
  logic [DW-1:0] data_in = '0;
  logic alloc_ready, ld_resp_valid, cache_wr_valid;
  logic [TAGW-1:0] ld_resp_tag;
  logic [1:0] ld_resp_kind;
  logic [DW-1:0] ld_resp_data, cache_wr_data;
  logic [AW-1:0] cache_wr_addr;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [AW-1:0] log_addr [8];
  logic [DW-1:0] log_data [8];
  int nlog;

  always #2 clk = ~clk;

  store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TAGW(TAGW)) u_store_buffer (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_ready(alloc_ready),
    .addr_we(addr_we), .addr_tag(addr_tag), .addr_in(addr_in),
    .data_we(data_we), .data_tag(data_tag), .data_in(data_in),
    .commit_valid(commit_valid), .commit_tag(commit_tag), .flush(flush),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .ld_resp_valid(ld_resp_valid), .ld_resp_tag(ld_resp_tag),
    .ld_resp_kind(ld_resp_kind), .ld_resp_data(ld_resp_data),
    .cache_wr_valid(cache_wr_valid), .cache_wr_addr(cache_wr_addr),
    .cache_wr_data(cache_wr_data), .cache_wr_ready(cache_wr_ready));

  function automatic logic [AW-1:0] st_addr(int t);
    if (t == 3 || t == 5) return 32'h200;
    return 32'h100 + 32'(4 * t);
  endfunction

  function automatic logic [DW-1:0] st_data(int t);
    return 32'hA000_0000 + 32'(t);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_alloc(int t);
    alloc_valid = 1; alloc_tag = TAGW'(t);
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic wr_addr(int t, logic [AW-1:0] a);
    addr_we = 1; addr_tag = TAGW'(t); addr_in = a;
    @(negedge clk);
    addr_we = 0;
  endtask

  task automatic wr_data(int t, logic [DW-1:0] d);
    data_we = 1; data_tag = TAGW'(t); data_in = d;
    @(negedge clk);
    data_we = 0;
  endtask

  task automatic do_commit(int t);
    commit_valid = 1; commit_tag = TAGW'(t);
    @(negedge clk);
    commit_valid = 0;
  endtask

  task automatic do_load(string req, int t, logic [AW-1:0] a, logic [1:0] k, logic [DW-1:0] d);
    ld_valid = 1; ld_tag = TAGW'(t); ld_addr = a;
    @(negedge clk);
    ld_valid = 0;
    chk(req, "resp_valid", 32'(ld_resp_valid), 32'd1);
    chk(req, "resp_tag", 32'(ld_resp_tag), 32'(t));
    chk(req, "resp_kind", 32'(ld_resp_kind), 32'(k));
    chk(req, "resp_data", ld_resp_data, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "alloc_ready", 32'(alloc_ready), 32'd1);
    chk("R1", "cache_wr_valid", 32'(cache_wr_valid), 32'd0);
    chk("R1", "ld_resp_valid", 32'(ld_resp_valid), 32'd0);
    rst = 0;
    @(negedge clk);
    chk("R1", "alloc_ready after reset", 32'(alloc_ready), 32'd1);

    // R2: fill to capacity, then offer one more that must be dropped
    for (int t = 0; t < DEPTH; t++) begin
      chk("R2", "ready before fill", 32'(alloc_ready), 32'd1);
      do_alloc(t);
    end
    chk("R2", "ready when full", 32'(alloc_ready), 32'd0);
    do_alloc(8);

    // R6: equal-age and wrapped-younger loads see no older stores
    do_load("R6", 0, 32'h200, K_CACHE, '0);
    do_load("R6", 40, 32'h200, K_CACHE, '0);
    // R7: older stores with unknown address stall the load
    do_load("R7", 10, 32'h200, K_STALL, '0);
    for (int t = 0; t < DEPTH - 1; t++) wr_addr(t, st_addr(t));
    do_load("R7", 10, 32'h104, K_STALL, '0);
    wr_addr(7, st_addr(7));

    // R8: youngest older match (tag 5) has no data yet
    wr_data(3, st_data(3));
    do_load("R8", 10, 32'h200, K_STALL, '0);
    wr_data(5, st_data(5));
    do_load("R8", 10, 32'h202, K_FWD, st_data(5));
    do_load("R8", 4, 32'h200, K_FWD, st_data(3));
    do_load("R9", 3, 32'h200, K_CACHE, '0);
    do_load("R9", 10, 32'h300, K_CACHE, '0);

    // R3: commit before data is known
    do_commit(0);
    chk("R3", "no offer without data", 32'(cache_wr_valid), 32'd0);
    for (int t = 0; t < DEPTH; t++) if (t != 3 && t != 5) wr_data(t, st_data(t));
    chk("R3", "offer valid", 32'(cache_wr_valid), 32'd1);
    chk("R3", "offer addr", cache_wr_addr, st_addr(0));
    @(negedge clk);
    chk("R4", "held addr", cache_wr_addr, st_addr(0));
    chk("R4", "held data", cache_wr_data, st_data(0));
    for (int t = 1; t < 4; t++) do_commit(t);

    // R4: drain in program order
    nlog = 0;
    cache_wr_ready = 1;
    for (int k = 0; k < 6; k++) begin
      if (cache_wr_valid && nlog < 8) begin
        log_addr[nlog] = cache_wr_addr;
        log_data[nlog] = cache_wr_data;
        nlog++;
      end
      @(negedge clk);
    end
    cache_wr_ready = 0;
    chk("R4", "drained count", 32'(nlog), 32'd4);
    for (int k = 0; k < 4; k++) begin
      chk("R4", "drain addr order", log_addr[k], st_addr(k));
      chk("R4", "drain data order", log_data[k], st_data(k));
    end

    // R10: commit tag 4, flush drops 5..7
    do_commit(4);
    flush = 1;
    @(negedge clk);
    flush = 0;
    chk("R10", "committed kept", 32'(cache_wr_valid), 32'd1);
    chk("R10", "kept addr", cache_wr_addr, st_addr(4));
    do_load("R10", 10, 32'h200, K_CACHE, '0);
    cache_wr_ready = 1;
    @(negedge clk);
    cache_wr_ready = 0;
    chk("R10", "empty after drain", 32'(cache_wr_valid), 32'd0);

    // R2 after flush: exactly DEPTH entries fit again
    for (int t = 20; t < 20 + DEPTH; t++) begin
      chk("R2", "ready during refill", 32'(alloc_ready), 32'd1);
      do_alloc(t);
    end
    chk("R2", "ready full again", 32'(alloc_ready), 32'd0);

    // R11: updates only reach matching tags
    for (int t = 20; t < 20 + DEPTH; t++) wr_addr(t, 32'h500 + 32'(4 * (t - 20)));
    wr_data(27, 32'h77);
    wr_data(30, 32'h99);
    wr_addr(31, 32'h51C);
    do_load("R11", 40, 32'h51C, K_FWD, 32'h77);
    do_load("R11", 40, 32'h504, K_STALL, '0);
    do_commit(30);
    chk("R11", "stray commit no offer", 32'(cache_wr_valid), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule